// File: doc/BRIEF.md
# Threshold-Triggered Word FIFO

This block is a synchronous word queue with a fill-level trigger. A producer pushes words and a consumer pops them through single-cycle strobes. A programmable level input sets when the trigger output changes. The same core serves both directions of a serial link, and a parameter selects the flavour. On the sending side the trigger is an active-high start flag. It rises once the queue holds at least level+1 words and stays up until the queue drains. On the receiving side the trigger is an active-low ready line. It is low for as long as the fill is above the level.

The level is offset by one, so a level of 0 means one word. The reported occupancy is one bit narrower than an exact count would need. Its top code therefore stands for both depth-1 and depth words. Overflow and underflow are sticky and are cleared only by a separate clear-flags strobe. A flush strobe empties the queue at once but leaves the error flags as they are.

Top module: `tff_top`

## Requirements
- R1: After reset the occupancy reads 0, both error flags read 0 and the popped-data output reads 0. The trigger reads 0 on the sending side and 1 on the receiving side.
- R2: Words leave in the order they were pushed. A pop that is accepted in one clock cycle presents its word on the popped-data output after that clock edge, and the word holds until the next accepted pop.
- R3: A push while the queue holds DEPTH words is dropped, and the overflow flag is set after that edge.
- R4: A pop while the queue is empty leaves the popped-data output unchanged, and the underflow flag is set after that edge.
- R5: The occupancy output shows the number of stored words from 0 to DEPTH-1. It reads DEPTH-1 for both DEPTH-1 and DEPTH stored words.
- R6: On the sending side (SIDE = SIDE_TX), the start flag reads 1 after the edge at which the stored count becomes greater than the level input. A level of 0 therefore starts on one word.
- R7: On the sending side, once the start flag is set it stays set while the queue is non-empty. This holds even if the level is raised or the count falls back to the level or below. It clears after the edge at which the queue becomes empty.
- R8: On the receiving side (SIDE = SIDE_RX), the ready output reads 0 after any edge at which the stored count is greater than the level, and reads 1 otherwise.
- R9: A flush empties the queue after that edge and ignores any push or pop in the same cycle. The error flags keep their values.
- R10: A clear-flags strobe resets both error flags. If an overflow or underflow happens in the same cycle, that flag reads 1 after the edge.
- R11: A push and a pop in the same cycle on a queue that is neither empty nor full leave the occupancy unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| push_i | input | 1 | Push strobe |
| push_data_i | input | WIDTH | Word to push |
| pop_i | input | 1 | Pop strobe |
| pop_data_o | output | WIDTH | Last word popped |
| level_i | input | log2(DEPTH) | Trigger level, offset by one |
| flush_i | input | 1 | Empty the queue |
| clr_flags_i | input | 1 | Clear the sticky error flags |
| fill_o | output | log2(DEPTH) | Saturating occupancy |
| ovf_o | output | 1 | Sticky overflow |
| udf_o | output | 1 | Sticky underflow |
| thr_o | output | 1 | Start flag (sending side) or active-low ready (receiving side) |

## Verification
A count register that drifts from the true number of stored words shows on the occupancy output in the cycle after the faulty edge. It also moves the trigger and the error flags at the wrong time. A pointer error stays hidden until the affected word is popped, and then it appears as a wrong popped value one cycle after that pop. The reference queue in the bench is compared on every clock. Because of this, a fault is reported at the first port where it becomes visible, not at the end of a long sequence.

// File: rtl/tff_pkg.sv
package tff_pkg;

    typedef enum logic {
        SIDE_TX = 1'b0,
        SIDE_RX = 1'b1
    } tff_side_e;

    // decoded per-cycle action of the queue
    typedef struct packed {
        logic push_ok;
        logic push_drop;
        logic pop_ok;
        logic pop_miss;
    } tff_act_t;

    // sticky error state
    typedef struct packed {
        logic ovf;
        logic udf;
    } tff_err_t;

    // sticky update: a new event beats a clear in the same cycle
    function automatic logic tff_sticky(input logic cur, input logic clr, input logic evt);
        return (cur & ~clr) | evt;
    endfunction

endpackage

// File: rtl/tff_ctrl.sv
module tff_ctrl
    import tff_pkg::*;
#(
    parameter int unsigned DEPTH = 512,
    localparam int unsigned CW = $clog2(DEPTH) + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push,
    input  logic          pop,
    input  logic          flush,
    input  logic          clr,
    output tff_act_t      act,
    output logic [CW-1:0] cnt_q,
    output logic [CW-1:0] cnt_nxt,
    output tff_err_t      err_q
);

    logic full;
    logic empty;

    always_comb begin
        full           = (cnt_q == CW'(DEPTH));
        empty          = (cnt_q == '0);
        act.push_ok    = push & ~full  & ~flush;
        act.push_drop  = push &  full  & ~flush;
        act.pop_ok     = pop  & ~empty & ~flush;
        act.pop_miss   = pop  &  empty & ~flush;
        if (flush) begin
            cnt_nxt = '0;
        end else begin
            cnt_nxt = cnt_q + CW'(act.push_ok) - CW'(act.pop_ok);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            err_q <= '0;
        end else begin
            cnt_q     <= cnt_nxt;
            err_q.ovf <= tff_sticky(err_q.ovf, clr, act.push_drop);
            err_q.udf <= tff_sticky(err_q.udf, clr, act.pop_miss);
        end
    end

endmodule

// File: rtl/tff_store.sv
module tff_store #(
    parameter int unsigned DEPTH = 512,
    parameter int unsigned WIDTH = 16,
    localparam int unsigned AW = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             rd_en,
    input  logic             flush,
    output logic [WIDTH-1:0] rd_data_q
);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wr_ptr;
    logic [AW-1:0]    rd_ptr;

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_ptr] <= wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr    <= '0;
            rd_ptr    <= '0;
            rd_data_q <= '0;
        end else if (flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
        end else begin
            if (wr_en) begin
                wr_ptr <= wr_ptr + 1'b1;
            end
            if (rd_en) begin
                rd_ptr    <= rd_ptr + 1'b1;
                rd_data_q <= mem[rd_ptr];
            end
        end
    end

endmodule

// File: rtl/tff_thresh.sv
module tff_thresh
    import tff_pkg::*;
#(
    parameter tff_side_e   SIDE = SIDE_TX,
    parameter int unsigned LW   = 9,
    localparam int unsigned CW  = LW + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [CW-1:0] cnt_nxt,
    input  logic [LW-1:0] level,
    output logic          thr
);

    logic above;
    assign above = (cnt_nxt > CW'(level));

    generate
        if (SIDE == SIDE_TX) begin : g_tx
            logic run_q;
            always_ff @(posedge clk) begin
                if (rst) begin
                    run_q <= 1'b0;
                end else if (cnt_nxt == '0) begin
                    run_q <= 1'b0;
                end else if (above) begin
                    run_q <= 1'b1;
                end
            end
            assign thr = run_q;
        end else begin : g_rx
            logic rdy_n_q;
            always_ff @(posedge clk) begin
                if (rst) begin
                    rdy_n_q <= 1'b1;
                end else begin
                    rdy_n_q <= ~above;
                end
            end
            assign thr = rdy_n_q;
        end
    endgenerate

endmodule

// File: rtl/tff_top.sv
module tff_top
    import tff_pkg::*;
#(
    parameter int unsigned DEPTH = 512,
    parameter int unsigned WIDTH = 16,
    parameter tff_side_e   SIDE  = SIDE_TX
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       push_i,
    input  logic [WIDTH-1:0]           push_data_i,
    input  logic                       pop_i,
    output logic [WIDTH-1:0]           pop_data_o,
    input  logic [$clog2(DEPTH)-1:0]   level_i,
    input  logic                       flush_i,
    input  logic                       clr_flags_i,
    output logic [$clog2(DEPTH)-1:0]   fill_o,
    output logic                       ovf_o,
    output logic                       udf_o,
    output logic                       thr_o
);

    localparam int unsigned AW = $clog2(DEPTH);
    localparam int unsigned CW = AW + 1;

    tff_act_t      act;
    tff_err_t      err_q;
    logic [CW-1:0] cnt_q;
    logic [CW-1:0] cnt_nxt;

    tff_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .push    (push_i),
        .pop     (pop_i),
        .flush   (flush_i),
        .clr     (clr_flags_i),
        .act     (act),
        .cnt_q   (cnt_q),
        .cnt_nxt (cnt_nxt),
        .err_q   (err_q)
    );

    tff_store #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_store (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (act.push_ok),
        .wr_data   (push_data_i),
        .rd_en     (act.pop_ok),
        .flush     (flush_i),
        .rd_data_q (pop_data_o)
    );

    tff_thresh #(.SIDE(SIDE), .LW(AW)) u_thresh (
        .clk     (clk),
        .rst     (rst),
        .cnt_nxt (cnt_nxt),
        .level   (level_i),
        .thr     (thr_o)
    );

    // occupancy saturates: a full queue reads the same as one short of full
    assign fill_o = (cnt_q == CW'(DEPTH)) ? AW'(DEPTH - 1) : cnt_q[AW-1:0];
    assign ovf_o  = err_q.ovf;
    assign udf_o  = err_q.udf;

endmodule

// File: rtl/tff_top_chk.sv
module tff_top_chk
    import tff_pkg::*;
#(
    parameter int unsigned DEPTH = 512,
    parameter int unsigned WIDTH = 16,
    parameter tff_side_e   SIDE  = SIDE_TX,
    localparam int unsigned AW   = $clog2(DEPTH)
) (
    input logic             clk,
    input logic             rst,
    input logic             push_i,
    input logic             pop_i,
    input logic             flush_i,
    input logic             clr_flags_i,
    input logic [AW-1:0]    level_i,
    input logic [AW-1:0]    fill_o,
    input logic [AW:0]      cnt_q,
    input logic [WIDTH-1:0] pop_data_o,
    input logic             ovf_o,
    input logic             udf_o,
    input logic             thr_o
);

    // R3
    overflow_set_chk: assert property (@(posedge clk) disable iff (rst)
        push_i && !flush_i && cnt_q == (AW+1)'(DEPTH) |=> ovf_o);

    // R3
    overflow_hold_chk: assert property (@(posedge clk) disable iff (rst)
        ovf_o && !clr_flags_i |=> ovf_o);

    // R4
    underflow_set_chk: assert property (@(posedge clk) disable iff (rst)
        pop_i && !flush_i && fill_o == '0 |=> udf_o);

    // R4
    underflow_stale_chk: assert property (@(posedge clk) disable iff (rst)
        pop_i && fill_o == '0 |=> $stable(pop_data_o));

    // R9
    flush_empty_chk: assert property (@(posedge clk) disable iff (rst)
        flush_i |=> fill_o == '0);

    // R11
    push_pop_level_chk: assert property (@(posedge clk) disable iff (rst)
        push_i && pop_i && !flush_i && cnt_q != '0 && cnt_q != (AW+1)'(DEPTH)
        |=> $stable(fill_o));

    generate
        if (SIDE == SIDE_TX) begin : g_tx
            // R7
            start_drop_chk: assert property (@(posedge clk) disable iff (rst)
                $fell(thr_o) |-> fill_o == '0);
            // R6
            start_cross_chk: assert property (@(posedge clk) disable iff (rst)
                push_i && !pop_i && !flush_i && cnt_q == {1'b0, level_i} |=> thr_o);
        end else begin : g_rx
            // R8
            ready_cross_chk: assert property (@(posedge clk) disable iff (rst)
                push_i && !pop_i && !flush_i && cnt_q == {1'b0, level_i} |=> !thr_o);
            // R8
            ready_empty_chk: assert property (@(posedge clk) disable iff (rst)
                flush_i |=> thr_o);
        end
    endgenerate

endmodule

bind tff_top tff_top_chk #(.DEPTH(DEPTH), .WIDTH(WIDTH), .SIDE(SIDE)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .push_i      (push_i),
    .pop_i       (pop_i),
    .flush_i     (flush_i),
    .clr_flags_i (clr_flags_i),
    .level_i     (level_i),
    .fill_o      (fill_o),
    .cnt_q       (cnt_q),
    .pop_data_o  (pop_data_o),
    .ovf_o       (ovf_o),
    .udf_o       (udf_o),
    .thr_o       (thr_o)
);

// File: tb/tff_top_test.sv
`timescale 1ns/1ps
module tff_top_test;
    import tff_pkg::*;

    localparam int TXD = 512;
    localparam int RXD = 16;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        push = 1'b0;
    logic [15:0] wdata = '0;
    logic        pop = 1'b0;
    logic        flush = 1'b0;
    logic        clr = 1'b0;
    logic [8:0]  tx_lvl = 9'h1FF;
    logic [3:0]  rx_lvl = 4'hF;

    logic [15:0] tx_data, rx_data;
    logic [8:0]  tx_fill;
    logic [3:0]  rx_fill;
    logic        tx_ovf, tx_udf, tx_thr, rx_ovf, rx_udf, rx_thr;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    tff_top #(.DEPTH(TXD), .WIDTH(16), .SIDE(SIDE_TX)) uut (
        .clk(clk), .rst(rst), .push_i(push), .push_data_i(wdata), .pop_i(pop),
        .pop_data_o(tx_data), .level_i(tx_lvl), .flush_i(flush), .clr_flags_i(clr),
        .fill_o(tx_fill), .ovf_o(tx_ovf), .udf_o(tx_udf), .thr_o(tx_thr)
    );

    tff_top #(.DEPTH(RXD), .WIDTH(16), .SIDE(SIDE_RX)) uut_rx (
        .clk(clk), .rst(rst), .push_i(push), .push_data_i(wdata), .pop_i(pop),
        .pop_data_o(rx_data), .level_i(rx_lvl), .flush_i(flush), .clr_flags_i(clr),
        .fill_o(rx_fill), .ovf_o(rx_ovf), .udf_o(rx_udf), .thr_o(rx_thr)
    );

    // reference state
    logic [15:0] tq[$];
    logic [15:0] rq[$];
    bit          t_ovf, t_udf, t_thr, r_ovf, r_udf, r_thr;
    logic [15:0] t_last, r_last;

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic mstep(ref logic [15:0] q[$], ref bit ovf, ref bit udf, ref bit thr,
                         ref logic [15:0] last, input int depth, input int lvl, input bit is_tx);
        bit e_o = 1'b0;
        bit e_u = 1'b0;
        if (flush) begin
            q.delete();
        end else begin
            bit full = (q.size() == depth);
            bit empty = (q.size() == 0);
            if (pop && !empty) last = q.pop_front();
            if (pop && empty) e_u = 1'b1;
            if (push && !full) q.push_back(wdata);
            if (push && full) e_o = 1'b1;
        end
        ovf = (ovf && !clr) || e_o;
        udf = (udf && !clr) || e_u;
        if (is_tx) begin
            if (q.size() == 0) thr = 1'b0;
            else if (q.size() > lvl) thr = 1'b1;
        end else begin
            thr = !(q.size() > lvl);
        end
    endtask

    function automatic int sat(input int n, input int depth);
        return (n == depth) ? depth - 1 : n;
    endfunction

    task automatic compare_all();
        chk("R5", "tx fill", int'(tx_fill), sat(tq.size(), TXD));
        chk("R3", "tx ovf", int'(tx_ovf), int'(t_ovf));
        chk("R4", "tx udf", int'(tx_udf), int'(t_udf));
        chk("R2", "tx data", int'(tx_data), int'(t_last));
        chk("R6", "tx start", int'(tx_thr), int'(t_thr));
        chk("R5", "rx fill", int'(rx_fill), sat(rq.size(), RXD));
        chk("R3", "rx ovf", int'(rx_ovf), int'(r_ovf));
        chk("R4", "rx udf", int'(rx_udf), int'(r_udf));
        chk("R2", "rx data", int'(rx_data), int'(r_last));
        chk("R8", "rx ready_n", int'(rx_thr), int'(r_thr));
    endtask

    // one clock: drive at negedge, model at the edge, compare at next negedge
    task automatic cyc(input bit pu, input logic [15:0] d, input bit po, input bit fl, input bit cl);
        push = pu; wdata = d; pop = po; flush = fl; clr = cl;
        @(posedge clk);
        mstep(tq, t_ovf, t_udf, t_thr, t_last, TXD, int'(tx_lvl), 1'b1);
        mstep(rq, r_ovf, r_udf, r_thr, r_last, RXD, int'(rx_lvl), 1'b0);
        @(negedge clk);
        push = 1'b0; pop = 1'b0; flush = 1'b0; clr = 1'b0;
        compare_all();
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        t_ovf = 0; t_udf = 0; t_thr = 0; t_last = '0;
        r_ovf = 0; r_udf = 0; r_thr = 1; r_last = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1", "tx fill", int'(tx_fill), 0);
        chk("R1", "tx flags", int'({tx_ovf, tx_udf}), 0);
        chk("R1", "tx start", int'(tx_thr), 0);
        chk("R1", "rx ready_n", int'(rx_thr), 1);
        chk("R1", "tx data", int'(tx_data), 0);

        // R6: level 3 means four words
        tx_lvl = 9'd3; rx_lvl = 4'd5;
        for (int i = 0; i < 3; i++) cyc(1, 16'h100 + 16'(i), 0, 0, 0);
        chk("R6", "start below level", int'(tx_thr), 0);
        cyc(1, 16'h103, 0, 0, 0);
        chk("R6", "start at level+1", int'(tx_thr), 1);

        // R7: raised level and falling fill keep the start flag
        tx_lvl = 9'd100;
        cyc(0, 0, 1, 0, 0);
        cyc(0, 0, 1, 0, 0);
        chk("R7", "start held", int'(tx_thr), 1);
        chk("R2", "second word out", int'(tx_data), 16'h101);
        cyc(0, 0, 1, 0, 0);
        cyc(0, 0, 1, 0, 0);
        chk("R7", "start cleared on empty", int'(tx_thr), 0);

        // R4: pop on empty
        cyc(0, 0, 1, 0, 0);
        chk("R4", "underflow", int'(tx_udf), 1);
        chk("R4", "stale data", int'(tx_data), 16'h103);

        // R10: clear
        cyc(0, 0, 0, 0, 1);
        chk("R10", "udf cleared", int'(tx_udf), 0);

        // R11: push with pop on a non-empty queue
        cyc(1, 16'h200, 0, 0, 0);
        cyc(1, 16'h201, 1, 0, 0);
        chk("R11", "fill unchanged", int'(tx_fill), 1);
        cyc(0, 0, 1, 0, 0);

        // R3, R5: fill to the top and beyond
        for (int i = 0; i < 520; i++) cyc(1, 16'(i), 0, 0, 0);
        chk("R5", "full reads depth-1", int'(tx_fill), 511);
        chk("R3", "tx overflow", int'(tx_ovf), 1);
        chk("R3", "rx overflow", int'(rx_ovf), 1);
        cyc(0, 0, 1, 0, 0);
        chk("R5", "511 words read 511", int'(tx_fill), 511);
        chk("R2", "first kept word", int'(tx_data), 0);

        // R9: flush keeps flags
        cyc(1, 16'hAAAA, 1, 1, 0);
        chk("R9", "flush empties", int'(tx_fill), 0);
        chk("R9", "flags kept", int'(tx_ovf), 1);
        chk("R9", "rx ready_n after flush", int'(rx_thr), 1);

        // R10: event beats clear in the same cycle
        cyc(0, 0, 1, 0, 1);
        chk("R10", "udf set wins", int'(tx_udf), 1);
        chk("R10", "ovf cleared", int'(tx_ovf), 0);

        // R6: level 0 means one word
        tx_lvl = 9'd0;
        cyc(1, 16'h55, 0, 0, 0);
        chk("R6", "level zero starts on one word", int'(tx_thr), 1);

        // mixed traffic against the model
        for (int i = 0; i < 600; i++) begin
            int r = $urandom_range(0, 99);
            tx_lvl = 9'($urandom_range(0, 12));
            rx_lvl = 4'($urandom_range(0, 15));
            cyc(r < 55, 16'($urandom), (r % 3) == 0, r == 97, r == 98);
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule